// File: doc/BRIEF.md
# NAND Flash Host Bridge

The bridge lets a host processor operate a raw 8-bit NAND flash device through byte-wide memory-mapped accesses. The host address space is split into 256-byte pages. Page 0 is the system register page, which this block leaves empty: reads give zero and writes change nothing. Page 1 is a small configuration space with a window-enable command register and a relocatable base address. The data window is a page whose location comes from that base. It holds the flash data port, a mode register whose bits drive the flash control pins directly, a constant status byte, and an interrupt status/mask pair. These registers feed one interrupt request line toward the system interrupt controller.

Each host access is a one-cycle request. Register accesses complete with `host_ack` one cycle after the request is accepted. A data-port access also needs a flash strobe, so a small transfer state machine handles it. The machine has three states: `XF_IDLE`, `XF_WRITE` and `XF_READ`. The transition `XF_IDLE -> XF_WRITE` is taken on an accepted data-port write. The transition `XF_IDLE -> XF_READ` is taken on an accepted data-port read. Both `XF_WRITE -> XF_IDLE` and `XF_READ -> XF_IDLE` are taken unconditionally after one cycle. Requests are accepted only in `XF_IDLE`. No ECC is computed here. The block only presents the ECC mode field and a one-cycle reset pulse for an external ECC engine.

Top module: `nand_host_bridge`

## Requirements
- R1: An address whose bits above bit 7 are 0 selects the system page: reads return 0x00 and writes leave every register unchanged. Bits above bit 7 equal to 1 select the configuration space, and this page decode takes priority over the window.
- R2: Configuration offset 0x04 holds the window enable in bit 1. A read returns 0x02 when enabled and 0x00 when disabled. The enable is 0 after reset.
- R3: Configuration offsets 0x10..0x13 hold the window base. Offset 0x10 is bits 7:0 and offset 0x13 is bits 31:24. Each offset is written and read back as one byte.
- R4: A window access is decoded only when the enable is set and the host address with its low 8 bits forced to zero equals the base. Any other access returns 0x00 and writes nothing. A base with a nonzero low byte therefore matches nothing.
- R5: A write to any window offset 0x00..0x03 places the byte on `nf_dout`, raises `nf_we` for exactly the cycle after acceptance, and sets interrupt status bit 0.
- R6: A read of window offsets 0x00..0x03 raises `nf_re` for exactly the cycle after acceptance. It returns the `nf_din` value present at the end of that cycle, with `host_ack` two cycles after acceptance. `nf_we` and `nf_re` are never high together.
- R7: The mode register at window offset 0x04 reads back as written. Bit 0 drives `nf_cle`, bit 1 drives `nf_ale`, bit 7 drives `nf_wp`, and `nf_ce_n` is the inverse of bit 4.
- R8: `ecc_mode` shows mode bits 6:5. A mode write with bits 6:5 equal to 01 or 11 produces a one-cycle `ecc_rst` pulse in the cycle after acceptance. Values 00 and 10 produce none.
- R9: A read of window offset 0x05 always returns 0x14.
- R10: Interrupt status at window offset 0x06 and interrupt mask at offset 0x07 are overwritten whole by host writes and read back unchanged.
- R11: `irq` is high exactly when mask bit 7 is set and the bitwise AND of mask and status is nonzero.
- R12: After reset, all registers are zero, `nf_ce_n` is high, and `irq`, `nf_we`, `nf_re`, `ecc_rst` and `host_rdata` are low. A register access raises `host_ack` one cycle after acceptance.
- R13: A request presented while a data strobe is in progress (state `XF_WRITE` or `XF_READ`) is ignored and causes no second strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | Access complete, read byte valid |
| host_rdata | output | 8 | Read byte |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_wp | output | 1 | Flash write-protect pin level |
| nf_we | output | 1 | Flash write strobe, one cycle |
| nf_re | output | 1 | Flash read strobe, one cycle |
| nf_dout | output | 8 | Byte driven toward the flash |
| nf_din | input | 8 | Byte from the flash |
| ecc_mode | output | 2 | ECC action field |
| ecc_rst | output | 1 | One-cycle reset pulse for the ECC engine |
| irq | output | 1 | Interrupt request |

## Verification
A single mode write updates several things in the same cycle: the flash control pins, the ECC mode field and the ECC reset pulse. The bench writes mode values that change all of them at once. It then samples the pins, `ecc_mode` and `ecc_rst` together on the first falling edge after acceptance. The pulse must be gone one cycle later.

A data-port write also lands in the same cycle as a status change: the strobe begins while status bit 0 is set, which can raise `irq` immediately. The bench checks `nf_we`, `nf_dout`, and the status readback with the resulting `irq` level against that single acceptance.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2
    } xfer_state_t;

    localparam logic [7:0] CFG_CMD_OFF   = 8'h04;
    localparam logic [7:0] CFG_BASE_OFF  = 8'h10;
    localparam logic [7:0] WIN_MODE_OFF  = 8'h04;
    localparam logic [7:0] WIN_STAT_OFF  = 8'h05;
    localparam logic [7:0] WIN_ISR_OFF   = 8'h06;
    localparam logic [7:0] WIN_IMR_OFF   = 8'h07;
    localparam logic [7:0] STATUS_CONST  = 8'h14;

    localparam int CMD_EN_BIT    = 1;
    localparam int MODE_CLE_BIT  = 0;
    localparam int MODE_ALE_BIT  = 1;
    localparam int MODE_CE_BIT   = 4;
    localparam int MODE_WP_BIT   = 7;
    localparam int IRQ_GLOBAL_BIT = 7;
endpackage

// File: rtl/nbr_cfg_regs.sv
module nbr_cfg_regs
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output logic [7:0]        rd_data
);
    localparam int LANES = ADDR_W / 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en <= 1'b0;
        end else if (wr_en && off == CFG_CMD_OFF) begin
            win_en <= wdata[CMD_EN_BIT];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= 8'h00;
            end else if (wr_en && off == (CFG_BASE_OFF + 8'(g))) begin
                lane_q <= wdata;
            end
        end
        assign win_base[g*8 +: 8] = lane_q;
    end

    always_comb begin
        rd_data = 8'h00;
        if (off == CFG_CMD_OFF) begin
            rd_data[CMD_EN_BIT] = win_en;
        end
        for (int i = 0; i < LANES; i++) begin
            if (off == (CFG_BASE_OFF + 8'(i))) begin
                rd_data = win_base[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/nbr_win_regs.sv
module nbr_win_regs
    import nbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic       isr_wr,
    input  logic       imr_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic [7:0] mode_q,
    output logic [7:0] isr_q,
    output logic [7:0] imr_q,
    output logic       ecc_rst,
    output logic       irq
);
    logic ecc_kick;

    assign ecc_kick = (wdata[6:5] == 2'b01) || (wdata[6:5] == 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 8'h00;
            imr_q   <= 8'h00;
            isr_q   <= 8'h00;
            ecc_rst <= 1'b0;
        end else begin
            ecc_rst <= mode_wr && ecc_kick;
            if (mode_wr) begin
                mode_q <= wdata;
            end
            if (imr_wr) begin
                imr_q <= wdata;
            end
            if (isr_wr) begin
                isr_q <= wdata;
            end else if (data_wr) begin
                isr_q[0] <= 1'b1;
            end
        end
    end

    assign irq = imr_q[IRQ_GLOBAL_BIT] && (|(imr_q & isr_q));
endmodule

// File: rtl/nbr_xfer_fsm.sv
module nbr_xfer_fsm
    import nbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_wr,
    input  logic go_rd,
    input  logic reg_go,
    output logic idle,
    output logic nf_we,
    output logic nf_re,
    output logic capture,
    output logic ack
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (go_wr) begin
                    state_d = XF_WRITE;
                end else if (go_rd) begin
                    state_d = XF_READ;
                end
            end
            XF_WRITE: state_d = XF_IDLE;
            XF_READ:  state_d = XF_IDLE;
            default:  state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        idle    = (state_q == XF_IDLE);
        nf_we   = (state_q == XF_WRITE);
        nf_re   = (state_q == XF_READ);
        capture = (state_q == XF_READ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else begin
            ack <= reg_go || (state_q != XF_IDLE);
        end
    end
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_ack,
    output logic [7:0]        host_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_wp,
    output logic              nf_we,
    output logic              nf_re,
    output logic [7:0]        nf_dout,
    input  logic [7:0]        nf_din,
    output logic [1:0]        ecc_mode,
    output logic              ecc_rst,
    output logic              irq
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page;
    logic [7:0]        off;
    logic              fsm_idle, accept, capture;
    logic              sel_sys, sel_cfg, sel_win, is_data;
    logic              win_en;
    logic [ADDR_W-1:0] win_base;
    logic [7:0]        cfg_rd, win_rd, rd_mux;
    logic              cfg_wr, mode_wr, isr_wr, imr_wr;
    logic              data_wr_go, data_rd_go, reg_go;
    logic [7:0]        mode_q, isr_q, imr_q;

    assign page    = host_addr[ADDR_W-1:8];
    assign off     = host_addr[7:0];
    assign sel_sys = (page == PAGE_W'(0));
    assign sel_cfg = (page == PAGE_W'(1));
    assign sel_win = !sel_sys && !sel_cfg && win_en && ({page, 8'h00} == win_base);
    assign is_data = sel_win && (off[7:2] == 6'd0);
    assign accept  = host_req && fsm_idle;

    assign cfg_wr     = accept && host_we && sel_cfg;
    assign mode_wr    = accept && host_we && sel_win && (off == WIN_MODE_OFF);
    assign isr_wr     = accept && host_we && sel_win && (off == WIN_ISR_OFF);
    assign imr_wr     = accept && host_we && sel_win && (off == WIN_IMR_OFF);
    assign data_wr_go = accept && host_we && is_data;
    assign data_rd_go = accept && !host_we && is_data;
    assign reg_go     = accept && !is_data;

    nbr_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .off      (off),
        .wdata    (host_wdata),
        .win_en   (win_en),
        .win_base (win_base),
        .rd_data  (cfg_rd)
    );

    nbr_win_regs u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .isr_wr  (isr_wr),
        .imr_wr  (imr_wr),
        .data_wr (data_wr_go),
        .wdata   (host_wdata),
        .mode_q  (mode_q),
        .isr_q   (isr_q),
        .imr_q   (imr_q),
        .ecc_rst (ecc_rst),
        .irq     (irq)
    );

    nbr_xfer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_wr   (data_wr_go),
        .go_rd   (data_rd_go),
        .reg_go  (reg_go),
        .idle    (fsm_idle),
        .nf_we   (nf_we),
        .nf_re   (nf_re),
        .capture (capture),
        .ack     (host_ack)
    );

    always_comb begin
        unique case (off)
            WIN_MODE_OFF: win_rd = mode_q;
            WIN_STAT_OFF: win_rd = STATUS_CONST;
            WIN_ISR_OFF:  win_rd = isr_q;
            WIN_IMR_OFF:  win_rd = imr_q;
            default:      win_rd = 8'h00;
        endcase
    end

    always_comb begin
        if (sel_cfg) begin
            rd_mux = cfg_rd;
        end else if (sel_win) begin
            rd_mux = win_rd;
        end else begin
            rd_mux = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= 8'h00;
            nf_dout    <= 8'h00;
        end else begin
            if (capture) begin
                host_rdata <= nf_din;
            end else if (reg_go) begin
                host_rdata <= host_we ? 8'h00 : rd_mux;
            end
            if (data_wr_go) begin
                nf_dout <= host_wdata;
            end
        end
    end

    assign nf_cle   = mode_q[MODE_CLE_BIT];
    assign nf_ale   = mode_q[MODE_ALE_BIT];
    assign nf_ce_n  = !mode_q[MODE_CE_BIT];
    assign nf_wp    = mode_q[MODE_WP_BIT];
    assign ecc_mode = mode_q[6:5];
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       nf_we,
    input logic       nf_re,
    input logic       host_ack,
    input logic       ecc_rst,
    input logic       irq,
    input logic       mode_wr,
    input logic       data_wr_go,
    input logic       nf_ce_n,
    input logic [7:0] host_wdata,
    input logic [7:0] imr_q,
    input logic [7:0] isr_q
);
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nf_we |=> !nf_we);

    p_data_sets_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_go |=> isr_q[0]);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_we && nf_re));

    p_read_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nf_re |=> host_ack);

    p_ce_inverted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (nf_ce_n == !$past(host_wdata[4])));

    p_ecc_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_rst |=> !ecc_rst);

    p_irq_global_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> imr_q[7]);
endmodule

bind nand_host_bridge nbr_checker u_nbr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nf_we      (nf_we),
    .nf_re      (nf_re),
    .host_ack   (host_ack),
    .ecc_rst    (ecc_rst),
    .irq        (irq),
    .mode_wr    (mode_wr),
    .data_wr_go (data_wr_go),
    .nf_ce_n    (nf_ce_n),
    .host_wdata (host_wdata),
    .imr_q      (imr_q),
    .isr_q      (isr_q)
);

// File: tb/nand_host_bridge_bench.sv
module nand_host_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_addr = 32'h0;
    logic [7:0]  host_wdata = 8'h0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        nf_cle, nf_ale, nf_ce_n, nf_wp, nf_we, nf_re;
    logic [7:0]  nf_dout;
    logic [7:0]  nf_din = 8'h00;
    logic [1:0]  ecc_mode;
    logic        ecc_rst;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nand_host_bridge #(.ADDR_W(32)) u_nand_host_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_ce_n(nf_ce_n), .nf_wp(nf_wp), .nf_we(nf_we), .nf_re(nf_re),
        .nf_dout(nf_dout), .nf_din(nf_din), .ecc_mode(ecc_mode),
        .ecc_rst(ecc_rst), .irq(irq)
    );

    // {check, write, address, write byte, expected read byte}
    localparam logic [49:0] VEC [0:15] = '{
        {1'b0, 1'b1, 32'h0000_0104, 8'h02, 8'h00},
        {1'b1, 1'b0, 32'h0000_0104, 8'h00, 8'h02},
        {1'b0, 1'b1, 32'h0000_0110, 8'h00, 8'h00},
        {1'b0, 1'b1, 32'h0000_0111, 8'h2A, 8'h00},
        {1'b0, 1'b1, 32'h0000_0112, 8'h00, 8'h00},
        {1'b0, 1'b1, 32'h0000_0113, 8'h00, 8'h00},
        {1'b1, 1'b0, 32'h0000_0111, 8'h00, 8'h2A},
        {1'b1, 1'b0, 32'h0000_0113, 8'h00, 8'h00},
        {1'b1, 1'b0, 32'h0000_2A05, 8'h00, 8'h14},
        {1'b0, 1'b1, 32'h0000_2A04, 8'h93, 8'h00},
        {1'b1, 1'b0, 32'h0000_2A04, 8'h00, 8'h93},
        {1'b0, 1'b1, 32'h0000_2A07, 8'h81, 8'h00},
        {1'b1, 1'b0, 32'h0000_2A07, 8'h00, 8'h81},
        {1'b1, 1'b0, 32'h0000_0050, 8'h00, 8'h00},
        {1'b1, 1'b0, 32'h0000_2B05, 8'h00, 8'h00},
        {1'b1, 1'b0, 32'h0000_2A08, 8'h00, 8'h00}
    };

    function automatic string row_tag(int i);
        case (i)
            1:       return "R2";
            6, 7:    return "R3";
            8:       return "R9";
            10:      return "R7";
            12:      return "R10";
            13:      return "R1";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_req(logic we, logic [31:0] addr, logic [7:0] wd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic do_acc(logic we, logic [31:0] addr, logic [7:0] wd,
                          output logic [7:0] rd, output int lat);
        drive_req(we, addr, wd);
        lat = 1;
        while (!host_ack && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lat;
        int cnt;

        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 rdata", host_rdata, 8'h00);
        check("R12 ce_n", nf_ce_n, 1'b1);
        check("R12 irq", irq, 1'b0);
        check("R12 strobes", {nf_we, nf_re, ecc_rst}, 3'b000);
        rst_n = 1'b1;
        do_acc(1'b0, 32'h104, 8'h00, rd, lat);
        check("R2 reset disabled", rd, 8'h00);
        check("R12 reg latency", lat, 1);

        for (int i = 0; i < 16; i++) begin
            do_acc(VEC[i][48], VEC[i][47:16], VEC[i][15:8], rd, lat);
            if (VEC[i][49]) check($sformatf("%s row %0d", row_tag(i), i), rd, VEC[i][7:0]);
        end

        // R7 pins from mode 0x93
        check("R7 pins", {nf_cle, nf_ale, nf_ce_n, nf_wp}, 4'b1101);
        // R11 interrupt gating
        check("R11 no status", irq, 1'b0);
        do_acc(1'b1, 32'h2A06, 8'h01, rd, lat);
        check("R11 masked status", irq, 1'b1);
        do_acc(1'b1, 32'h2A07, 8'h01, rd, lat);
        check("R11 no global", irq, 1'b0);
        do_acc(1'b1, 32'h2A07, 8'h81, rd, lat);
        do_acc(1'b1, 32'h2A06, 8'h00, rd, lat);
        check("R11 cleared", irq, 1'b0);
        do_acc(1'b0, 32'h2A06, 8'h00, rd, lat);
        check("R10 isr overwrite", rd, 8'h00);

        // R5 data write
        drive_req(1'b1, 32'h2A02, 8'h5C);
        check("R5 we strobe", nf_we, 1'b1);
        check("R5 dout", nf_dout, 8'h5C);
        check("R5 irq same", irq, 1'b1);
        @(negedge clk);
        check("R5 we one cycle", {nf_we, host_ack}, 2'b01);
        do_acc(1'b0, 32'h2A06, 8'h00, rd, lat);
        check("R5 isr bit0", rd, 8'h01);

        // R6 data read
        nf_din = 8'hC3;
        drive_req(1'b0, 32'h2A01, 8'h00);
        check("R6 re strobe", {nf_re, nf_we, host_ack}, 3'b100);
        @(negedge clk);
        check("R6 re done", {nf_re, host_ack}, 2'b01);
        check("R6 read data", host_rdata, 8'hC3);
        nf_din = 8'h3E;
        do_acc(1'b0, 32'h2A03, 8'h00, rd, lat);
        check("R6 latency", lat, 2);
        check("R6 data2", rd, 8'h3E);

        // R8 ECC action
        do_acc(1'b1, 32'h2A04, 8'h20, rd, lat);
        check("R8 pulse 01", {ecc_rst, ecc_mode}, 3'b101);
        @(negedge clk);
        check("R8 pulse ends", ecc_rst, 1'b0);
        do_acc(1'b1, 32'h2A04, 8'h40, rd, lat);
        check("R8 none 10", {ecc_rst, ecc_mode}, 3'b010);
        do_acc(1'b1, 32'h2A04, 8'h60, rd, lat);
        check("R8 pulse 11", {ecc_rst, ecc_mode}, 3'b111);
        do_acc(1'b1, 32'h2A04, 8'h00, rd, lat);
        check("R8 none 00", {ecc_rst, ecc_mode}, 3'b000);
        check("R7 ce off", nf_ce_n, 1'b1);

        // R4 disabled window
        do_acc(1'b1, 32'h104, 8'h00, rd, lat);
        do_acc(1'b0, 32'h104, 8'h00, rd, lat);
        check("R2 disabled read", rd, 8'h00);
        do_acc(1'b1, 32'h2A07, 8'hFF, rd, lat);
        drive_req(1'b1, 32'h2A00, 8'hAA);
        check("R4 no strobe disabled", nf_we, 1'b0);
        do_acc(1'b0, 32'h2A05, 8'h00, rd, lat);
        check("R4 disabled read", rd, 8'h00);
        do_acc(1'b1, 32'h104, 8'h02, rd, lat);
        do_acc(1'b0, 32'h2A07, 8'h00, rd, lat);
        check("R4 dropped write", rd, 8'h81);
        // R4 base low byte nonzero
        do_acc(1'b1, 32'h110, 8'h01, rd, lat);
        do_acc(1'b0, 32'h2A05, 8'h00, rd, lat);
        check("R4 low byte base", rd, 8'h00);
        do_acc(1'b1, 32'h110, 8'h00, rd, lat);
        do_acc(1'b0, 32'h2A05, 8'h00, rd, lat);
        check("R4 restored", rd, 8'h14);

        // R1 system page
        do_acc(1'b1, 32'h0004, 8'h00, rd, lat);
        do_acc(1'b1, 32'h0050, 8'hFF, rd, lat);
        do_acc(1'b0, 32'h0050, 8'h00, rd, lat);
        check("R1 sys read", rd, 8'h00);
        do_acc(1'b0, 32'h0104, 8'h00, rd, lat);
        check("R1 cfg untouched", rd, 8'h02);

        // R13 request held during strobe
        cnt = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 32'h2A00; host_wdata = 8'h11;
        @(negedge clk);
        cnt += int'(nf_we);
        @(negedge clk);
        cnt += int'(nf_we);
        host_req = 1'b0;
        @(negedge clk);
        cnt += int'(nf_we);
        check("R13 single strobe", cnt, 1);
        check("R13 dout", nf_dout, 8'h11);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule